// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block sequences a network clock synchronizer through three operating states. In Holdover the output frequency comes from a stored value. In TIE Correction the present output-to-input phase offset is captured. In Normal the loop tracks the selected input reference. The block reads a request for Normal operation, a flag from the reference monitor that marks the selected reference as disrupted, a hitless-switch strap, a one-cycle pulse that signals a change of selected reference, and a fast-acquisition enable.

The block drives four controls. The first is a freeze command to the holdover value store. The second is a one-cycle phase-align command, issued when the loop jumps its output phase onto the reference. The third is a phase-preserve command, issued while the offset is captured. The fourth is a lock indication that rises once the loop has spent its acquisition time in Normal. The current state is exported for status readback. The loop arithmetic, the reference monitors and the automatic reference selector all sit outside the block.

Recovery from Holdover takes one of two paths. With the strap low, the block goes straight to Normal and realigns phase. With the strap high, it passes through TIE Correction and keeps the phase offset. A change of reference always forces the TIE Correction path, whatever the strap is set to.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset the state is Holdover (code 2'b00), freezeStore is 1, and alignCmd, preserveCmd and lockAcquired are 0.
- R2: The block stays in Holdover while refDisrupted is 1 or normalReq is 0.
- R3: From Holdover, when normalReq is 1, refDisrupted is 0, hitlessSel is 0 and no reference change is pending, the next state is Normal. alignCmd is 1 for exactly that first Normal cycle.
- R4: From Holdover, when the same clear conditions hold but hitlessSel is 1, the next state is TIE Correction (code 2'b01). That state lasts one cycle with preserveCmd at 1 and is followed by Normal (code 2'b10), with alignCmd staying 0.
- R5: In Normal or TIE Correction, refDisrupted at 1 or normalReq at 0 sends the block to Holdover on the next cycle.
- R6: A refChange pulse in any state sends the block to (or keeps it in) Holdover on the next cycle. It marks a pending change, and the next recovery then goes through TIE Correction even when hitlessSel is 0. The mark is cleared once TIE Correction hands over to Normal.
- R7: A refChange pulse that arrives in the same cycle as clear conditions in Holdover wins, so the block stays in Holdover for that cycle.
- R8: freezeStore is 1 in Holdover and TIE Correction and 0 in Normal.
- R9: lockAcquired becomes 1 once the block has spent SLOW_ACQ_CYC consecutive cycles in Normal, or FAST_ACQ_CYC cycles when fastLock is 1. It drops to 0 in the same cycle the block leaves Normal.
- R10: modeState carries the codes Holdover 2'b00, TIE Correction 2'b01 and Normal 2'b10, and never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| normalReq | input | 1 | 1 requests Normal operation, 0 forces Holdover |
| refDisrupted | input | 1 | Selected reference flagged as disrupted |
| hitlessSel | input | 1 | Strap: 1 keeps phase through TIE Correction, 0 realigns |
| refChange | input | 1 | One-cycle pulse: selected reference has changed |
| fastLock | input | 1 | Selects the short acquisition window |
| modeState | output | 2 | Current state code |
| freezeStore | output | 1 | Holds the holdover value store |
| alignCmd | output | 1 | One-cycle command to align output phase to the reference |
| preserveCmd | output | 1 | Command to capture and keep the present phase offset |
| lockAcquired | output | 1 | Acquisition window in Normal has elapsed |

## Verification
The recovery transition is driven once with the strap low and once with it high. Comparing the two shows whether the strap alone selects between the align pulse and the one-cycle TIE state. Reference-change pulses are then placed in Normal, in TIE Correction and in Holdover, including a pulse that lands together with a disruption clear. These cases separate the pending-change override and its priority from the plain strap path. Long dwells in Normal, with fastLock both high and low, tell the two acquisition windows apart. A pseudo-random stretch of all inputs follows, compared cycle by cycle against the behavioural model, to reach orderings the directed cases miss.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'b00,
    ST_TIE  = 2'b01,
    ST_NORM = 2'b10
  } modeState_e;

  // Strobes from the sequencer to the command datapath, valid for the
  // transition taken at the coming edge.
  typedef struct packed {
    logic alignGo;   // direct Holdover -> Normal jump
    logic tieGo;     // next state is TIE Correction
    logic normNext;  // next state is Normal
  } modeStrobe_t;

endpackage

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm
  import sync_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        normalReq,
  input  logic        refDisrupted,
  input  logic        hitlessSel,
  input  logic        refChange,
  output modeState_e  curState,
  output modeStrobe_t strobe
);

  modeState_e stateQ, stateD;
  logic       pendTieQ, pendTieD;
  logic       refUsable;

  assign refUsable = normalReq && !refDisrupted;

  always_comb begin
    stateD          = stateQ;
    pendTieD        = pendTieQ;
    strobe          = '0;
    if (refChange) pendTieD = 1'b1;
    unique case (stateQ)
      ST_HOLD: begin
        // a reference change outranks a clear in the same cycle
        if (!refChange && refUsable) begin
          if (hitlessSel || pendTieQ) begin
            stateD = ST_TIE;
          end else begin
            stateD        = ST_NORM;
            strobe.alignGo = 1'b1;
          end
        end
      end
      ST_TIE: begin
        if (refChange || !refUsable) begin
          stateD = ST_HOLD;
        end else begin
          stateD   = ST_NORM;
          pendTieD = 1'b0;
        end
      end
      ST_NORM: begin
        if (refChange || !refUsable) stateD = ST_HOLD;
      end
      default: stateD = ST_HOLD;
    endcase
    strobe.tieGo    = (stateD == ST_TIE);
    strobe.normNext = (stateD == ST_NORM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_HOLD;
      pendTieQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      pendTieQ <= pendTieD;
    end
  end

  assign curState = stateQ;

  // R4: TIE Correction never lasts more than one cycle
  a_r4_tie_single: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_TIE |=> stateQ != ST_TIE);

  // R6: a reference change always lands in Holdover
  a_r6_change_to_hold: assert property (@(posedge clk) disable iff (!rstN)
    refChange |=> stateQ == ST_HOLD);

  // R2: disruption keeps Holdover
  a_r2_hold_disrupted: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && refDisrupted) |=> stateQ == ST_HOLD);

  // R10: unused code never appears
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != 2'b11);

endmodule

// File: rtl/sync_mode_cmd.sv
module sync_mode_cmd
  import sync_mode_pkg::*;
#(
  parameter int SLOW_ACQ_CYC = 48,
  parameter int FAST_ACQ_CYC = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fastLock,
  input  modeStrobe_t strobe,
  output logic        freezeStore,
  output logic        alignCmd,
  output logic        preserveCmd,
  output logic        lockAcquired
);

  localparam int CW = $clog2(SLOW_ACQ_CYC + 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_ACQ_CYC);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_ACQ_CYC);

  logic [CW-1:0] acqCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeStore <= 1'b1;
      alignCmd    <= 1'b0;
      preserveCmd <= 1'b0;
      acqCnt      <= '0;
    end else begin
      freezeStore <= !strobe.normNext;
      alignCmd    <= strobe.alignGo;
      preserveCmd <= strobe.tieGo;
      if (!strobe.normNext)       acqCnt <= '0;
      else if (acqCnt != SLOW_LIM) acqCnt <= acqCnt + 1'b1;
    end
  end

  assign lockAcquired = acqCnt >= (fastLock ? FAST_LIM : SLOW_LIM);

  // R3: the align command is a single-cycle pulse
  a_r3_align_pulse: assert property (@(posedge clk) disable iff (!rstN)
    alignCmd |=> !alignCmd);

  // R9: leaving Normal drops the lock indication at once
  a_r9_unlock_on_leave: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freezeStore) |-> !lockAcquired);

  // R8: no command is issued while the store is frozen and aligning
  a_r8_align_unfrozen: assert property (@(posedge clk) disable iff (!rstN)
    alignCmd |-> !freezeStore && !preserveCmd);

endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int SLOW_ACQ_CYC = 48,
  parameter int FAST_ACQ_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       normalReq,
  input  logic       refDisrupted,
  input  logic       hitlessSel,
  input  logic       refChange,
  input  logic       fastLock,
  output logic [1:0] modeState,
  output logic       freezeStore,
  output logic       alignCmd,
  output logic       preserveCmd,
  output logic       lockAcquired
);

  modeState_e  curState;
  modeStrobe_t strobe;

  sync_mode_fsm fsm_i (
    .clk          (clk),
    .rstN         (rstN),
    .normalReq    (normalReq),
    .refDisrupted (refDisrupted),
    .hitlessSel   (hitlessSel),
    .refChange    (refChange),
    .curState     (curState),
    .strobe       (strobe)
  );

  sync_mode_cmd #(
    .SLOW_ACQ_CYC (SLOW_ACQ_CYC),
    .FAST_ACQ_CYC (FAST_ACQ_CYC)
  ) cmd_i (
    .clk          (clk),
    .rstN         (rstN),
    .fastLock     (fastLock),
    .strobe       (strobe),
    .freezeStore  (freezeStore),
    .alignCmd     (alignCmd),
    .preserveCmd  (preserveCmd),
    .lockAcquired (lockAcquired)
  );

  assign modeState = curState;

  // R8: freeze follows the exported state
  a_r8_freeze_state: assert property (@(posedge clk) disable iff (!rstN)
    freezeStore == (modeState != 2'b10));

endmodule

// File: tb/sync_mode_ctrl_tb.sv
module sync_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 48;
  localparam int FAST = 12;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic normalReq = 1'b0, refDisrupted = 1'b1, hitlessSel = 1'b0;
  logic refChange = 1'b0, fastLock = 1'b0;
  logic [1:0] modeState;
  logic freezeStore, alignCmd, preserveCmd, lockAcquired;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference
  int mState = 0;
  bit mPend = 0;
  bit mAlign = 0;
  int mCnt = 0;
  bit modelLive = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_mode_ctrl #(.SLOW_ACQ_CYC(SLOW), .FAST_ACQ_CYC(FAST)) dut_i (
    .clk(clk), .rstN(rstN), .normalReq(normalReq), .refDisrupted(refDisrupted),
    .hitlessSel(hitlessSel), .refChange(refChange), .fastLock(fastLock),
    .modeState(modeState), .freezeStore(freezeStore), .alignCmd(alignCmd),
    .preserveCmd(preserveCmd), .lockAcquired(lockAcquired));

  always @(posedge clk) begin
    int nxt;
    bit usable;
    modelLive = 1;
    if (!rstN) begin
      mState = 0; mPend = 0; mAlign = 0; mCnt = 0;
    end else begin
      usable = normalReq && !refDisrupted;
      nxt = mState;
      mAlign = 0;
      if (mState == 0) begin
        if (!refChange && usable) begin
          if (hitlessSel || mPend) nxt = 1;
          else begin nxt = 2; mAlign = 1; end
        end
      end else if (mState == 1) begin
        if (refChange || !usable) nxt = 0;
        else begin nxt = 2; mPend = 0; end
      end else begin
        if (refChange || !usable) nxt = 0;
      end
      if (refChange) mPend = 1;
      mState = nxt;
      if (nxt == 2) mCnt = (mCnt < SLOW) ? mCnt + 1 : SLOW;
      else mCnt = 0;
    end
  end

  task automatic check1(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare all outputs against the model, away from the clock edge
  always @(negedge clk) begin
    if (modelLive && !done) begin
      check1("R10", "modeState", int'(modeState), mState);
      check1("R8", "freezeStore", int'(freezeStore), (mState != 2) ? 1 : 0);
      check1("R3", "alignCmd", int'(alignCmd), int'(mAlign));
      check1("R4", "preserveCmd", int'(preserveCmd), (mState == 1) ? 1 : 0);
      check1("R9", "lockAcquired", int'(lockAcquired),
             (mCnt >= (fastLock ? FAST : SLOW)) ? 1 : 0);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  // drive inputs after the negedge compare, hold for n cycles
  task automatic drive(bit nr, bit dis, bit hs, bit chg, bit fl, int n);
    @(negedge clk); #1;
    normalReq = nr; refDisrupted = dis; hitlessSel = hs; refChange = chg; fastLock = fl;
    if (chg) begin
      @(negedge clk); #1;
      refChange = 0;
      n = n - 1;
    end
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    // R1: reset state compared by the per-cycle monitor
    @(negedge clk); #1; rstN = 1;
    // R2: disrupted reference holds Holdover
    drive(1, 1, 0, 0, 0, 6);
    // R2: no Normal request holds Holdover
    drive(0, 0, 0, 0, 0, 4);
    // R3: direct recovery, then slow lock (R9)
    drive(1, 0, 0, 0, 0, SLOW + 4);
    // R5: disruption in Normal
    drive(1, 1, 0, 0, 0, 3);
    // R4: hitless recovery through TIE, fast lock (R9)
    drive(1, 0, 1, 0, 1, FAST + 4);
    // R5: Normal request dropped
    drive(0, 0, 1, 0, 1, 3);
    drive(1, 0, 0, 0, 0, 5);
    // R6: reference change in Normal with strap low forces TIE path
    drive(1, 0, 0, 1, 0, 6);
    // R7: change with clear conditions in Holdover
    drive(1, 1, 0, 0, 0, 3);
    drive(1, 0, 0, 1, 0, 6);
    // R6: change landing in TIE Correction
    drive(1, 1, 1, 0, 0, 2);
    @(negedge clk); #1; refDisrupted = 0; hitlessSel = 1;
    @(negedge clk); #1; refChange = 1; hitlessSel = 0;
    @(negedge clk); #1; refChange = 0;
    repeat (6) @(negedge clk);
    // R9: fastLock toggled while in Normal
    drive(1, 0, 0, 0, 0, FAST + 2);
    drive(1, 0, 0, 0, 1, 3);
    drive(1, 0, 0, 0, 0, SLOW);
    // pseudo-random stretch over all inputs
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      normalReq    = (lfsr[3:0] != 0);
      refDisrupted = (lfsr[7:5] == 0);
      hitlessSel   = lfsr[8];
      refChange    = (lfsr[12:9] == 0);
      fastLock     = lfsr[14];
    end
    // R1: reset again mid-run
    @(negedge clk); #1; rstN = 0;
    repeat (2) @(negedge clk);
    #1; rstN = 1;
    drive(1, 0, 0, 0, 0, 4);
    finishRun();
  end

endmodule